// File: doc/BRIEF.md
# Asynchronous Static Memory Bus Sequencer

The sequencer turns single read or write requests on an internal request/acknowledge port into timed cycles on a shared external static memory bus. Several devices share the address lines, the data lines, the output-enable and write-enable strobes and the byte-lane enables. Each device has its own active-low chip select. Only one external access is in flight at any time.

Every chip select carries its own timing word. The word holds six 4-bit cycle counts: byte-lane setup, address setup, address hold, data setup, data hold and bus turnaround. A chip select may use a second timing word for writes. It may also put the address on the data lines during the address phases (multiplexed mode), run an 8- or 16-bit data bus, and stretch data setup with a wait input whose active level is programmable. Software converts device timings into cycle counts before it programs these words.

A requester holds `req_valid` and the request fields steady until `req_ack` pulses. Read data is valid on `rsp_rdata` from the acknowledge cycle until the next read captures new data.

Top module: `amb_seq`

## Requirements
- R1: A request is accepted only when the sequencer is idle and is not acknowledging. At most one chip select is low at any time, and it is always the one named by the accepted request.
- R2: An access runs its phases in this fixed order: byte-lane setup (byte lanes low, chip select high), then address setup, address hold, data setup and data hold (chip select low for all four), then turnaround. Each phase lasts its programmed count in cycles, and a count of zero skips the phase. The timing word is laid out as bls[3:0], aset[7:4], ahld[11:8], dset[15:12], dhld[19:16] and turn[23:20].
- R3: Data setup lasts at least one cycle, even when its count is zero.
- R4: A write to a chip select whose write-override bit is set takes address setup, address hold, data setup, data hold and turnaround from the write timing word. Byte-lane setup always comes from the read word. Reads always use the read word.
- R5: Output enable is low during data setup and data hold of a read. Write enable is low during data setup of a write. The two are never low together.
- R6: A write drives the data lines with the write data during data setup and data hold. In multiplexed mode the data lines also carry address bits [15:0] during address setup and address hold. Address hold is skipped when multiplexing is off. The data lines are never driven while output enable is low.
- R7: Read data is sampled from the data lines on the last cycle of data setup. On an 8-bit chip select only the low byte is kept, and it is zero-extended.
- R8: While they are asserted, the byte-lane enables equal the inverted byte mask on a 16-bit chip select, and 2'b10 (lane 0 only) on an 8-bit chip select. On an 8-bit write the upper data byte is driven as zero.
- R9: When wait is enabled for the chip select, and the wait input is at its active level (high if the polarity bit is set, otherwise low), the data setup phase holds. When wait is disabled, the wait input has no effect.
- R10: `req_ack` pulses for exactly one cycle, the cycle after the last cycle of the final phase that is not skipped (normally turnaround). At that point `rsp_rdata` holds the read result.
- R11: After reset all chip selects, strobes and byte lanes are high, the data lines are not driven and `req_ack` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | CS_W | Target chip select index |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, bit per lane, 1 = lane used |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Captured read data |
| cfg_rd_tim | input | NUM_CS*24 | Read timing word per chip select |
| cfg_wr_tim | input | NUM_CS*24 | Write timing word per chip select |
| cfg_wr_sep | input | NUM_CS | Use the write timing word for writes |
| cfg_mux | input | NUM_CS | Address/data multiplexing enable |
| cfg_wide | input | NUM_CS | 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_wait_en | input | NUM_CS | Honour the wait input |
| cfg_wait_hi | input | NUM_CS | Wait is active high |
| mem_cs_n | output | NUM_CS | Chip selects, active low |
| mem_addr | output | ADDR_W | Address lines |
| mem_bl_n | output | 2 | Byte-lane enables, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 16 | Data lines, outbound value |
| mem_dq_oe | output | 1 | Data lines driven |
| mem_dq_in | input | 16 | Data lines, inbound value |
| mem_wait | input | 1 | Wait input from the device |

## Verification
The bench builds the sequencer with its defaults: two chip selects and a 20-bit address. Two chip selects are enough to show that the unselected one stays high and that per-select settings really are independent. The 4-bit phase counts allow a table of timing words that mixes skipped phases, a data setup of zero (which must become one cycle), an override write word and an all-zero write. The bench counts the cycles of every strobe and changes the inbound data every cycle, so the capture cycle can be checked exactly. Directed runs drive the wait input at both polarities and with wait disabled.

// File: rtl/amb_pkg.sv
package amb_pkg;
    localparam int PH_W  = 4;          // bits per phase count
    localparam int TIM_W = 6 * PH_W;   // one timing word

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_BLS  = 3'd1,
        PH_ASET = 3'd2,
        PH_AHLD = 3'd3,
        PH_DSET = 3'd4,
        PH_DHLD = 3'd5,
        PH_TURN = 3'd6
    } phase_e;

    typedef struct packed {
        logic [PH_W-1:0] turn;
        logic [PH_W-1:0] dhld;
        logic [PH_W-1:0] dset;
        logic [PH_W-1:0] ahld;
        logic [PH_W-1:0] aset;
        logic [PH_W-1:0] bls;
    } timing_t;

    function automatic logic [PH_W-1:0] phase_len(input phase_e p, input timing_t t);
        case (p)
            PH_BLS:  return t.bls;
            PH_ASET: return t.aset;
            PH_AHLD: return t.ahld;
            PH_DSET: return t.dset;
            PH_DHLD: return t.dhld;
            PH_TURN: return t.turn;
            default: return '0;
        endcase
    endfunction

    // first phase after cur whose length is not zero, or idle
    function automatic phase_e next_phase(input phase_e cur, input timing_t t);
        phase_e r;
        logic   hit;
        r   = PH_IDLE;
        hit = 1'b0;
        for (int p = 1; p < 7; p++) begin
            if (!hit && p > int'(cur) && phase_len(phase_e'(3'(p)), t) != '0) begin
                r   = phase_e'(3'(p));
                hit = 1'b1;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/amb_timing_sel.sv
module amb_timing_sel
    import amb_pkg::*;
#(
    parameter  int NUM_CS = 2,
    localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic [NUM_CS*TIM_W-1:0] rd_tim_flat,
    input  logic [NUM_CS*TIM_W-1:0] wr_tim_flat,
    input  logic [NUM_CS-1:0]       wr_sep,
    input  logic [NUM_CS-1:0]       mux_en,
    input  logic [CS_W-1:0]         cs,
    input  logic                    is_write,
    output timing_t                 eff
);
    timing_t rd_arr [NUM_CS];
    timing_t wr_arr [NUM_CS];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_unpack
        assign rd_arr[g] = rd_tim_flat[g*TIM_W +: TIM_W];
        assign wr_arr[g] = wr_tim_flat[g*TIM_W +: TIM_W];
    end

    always_comb begin
        timing_t pick;
        pick = rd_arr[cs];
        if (is_write && wr_sep[cs]) begin
            pick     = wr_arr[cs];
            pick.bls = rd_arr[cs].bls;     // byte-lane setup always from read word
        end
        if (!mux_en[cs]) pick.ahld = '0;   // address hold only when multiplexed
        if (pick.dset == '0) pick.dset = PH_W'(1);
        eff = pick;
    end
endmodule

// File: rtl/amb_phase_fsm.sv
module amb_phase_fsm
    import amb_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  timing_t start_tim,
    input  logic    wait_act,
    output phase_e  phase,
    output logic    done_pulse,
    output logic    capture
);
    typedef struct packed {
        phase_e          ph;
        logic [PH_W-1:0] cnt;
        timing_t         tim;
        logic            ack;
    } st_t;

    st_t  s_d, s_q;
    logic hold;

    always_comb begin
        s_d     = s_q;
        s_d.ack = 1'b0;
        hold    = (s_q.ph == PH_DSET) && wait_act;
        if (s_q.ph == PH_IDLE) begin
            if (start) begin
                s_d.tim = start_tim;
                s_d.ph  = next_phase(PH_IDLE, start_tim);
                s_d.cnt = phase_len(s_d.ph, start_tim);
            end
        end else if (!hold) begin
            if (s_q.cnt > PH_W'(1)) begin
                s_d.cnt = s_q.cnt - 1'b1;
            end else begin
                s_d.ph  = next_phase(s_q.ph, s_q.tim);
                s_d.cnt = phase_len(s_d.ph, s_q.tim);
                s_d.ack = (s_d.ph == PH_IDLE);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign phase      = s_q.ph;
    assign done_pulse = s_q.ack;
    assign capture    = (s_q.ph == PH_DSET) && !hold && (s_q.cnt == PH_W'(1));

    assert_ack_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ack |=> !s_q.ack);

    assert_wait_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_DSET && wait_act) |=> (s_q.ph == PH_DSET && $stable(s_q.cnt)));

    assert_active_cnt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph != PH_IDLE) |-> (s_q.cnt != '0));

    assert_dhld_after_dset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_DSET && !wait_act && s_q.cnt == PH_W'(1)) |=> (s_q.ph != PH_DSET));
endmodule

// File: rtl/amb_seq.sv
module amb_seq
    import amb_pkg::*;
#(
    parameter  int NUM_CS = 2,
    parameter  int ADDR_W = 20,
    localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [CS_W-1:0]         req_cs,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [15:0]             req_wdata,
    input  logic [1:0]              req_be,
    output logic                    req_ack,
    output logic [15:0]             rsp_rdata,
    input  logic [NUM_CS*TIM_W-1:0] cfg_rd_tim,
    input  logic [NUM_CS*TIM_W-1:0] cfg_wr_tim,
    input  logic [NUM_CS-1:0]       cfg_wr_sep,
    input  logic [NUM_CS-1:0]       cfg_mux,
    input  logic [NUM_CS-1:0]       cfg_wide,
    input  logic [NUM_CS-1:0]       cfg_wait_en,
    input  logic [NUM_CS-1:0]       cfg_wait_hi,
    output logic [NUM_CS-1:0]       mem_cs_n,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [1:0]              mem_bl_n,
    output logic                    mem_oe_n,
    output logic                    mem_we_n,
    output logic [15:0]             mem_dq_out,
    output logic                    mem_dq_oe,
    input  logic [15:0]             mem_dq_in,
    input  logic                    mem_wait
);
    typedef struct packed {
        logic [CS_W-1:0]   cs;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [15:0]       wdata;
        logic [1:0]        be;
        logic              mux;
        logic              wide;
        logic              wen;
        logic              whi;
        logic [15:0]       rdata;
    } ctx_t;

    ctx_t    c_d, c_q;
    timing_t eff_tim;
    phase_e  phase;
    logic    done, capture, start, wait_act;
    logic    in_addr, in_data, in_cs, in_bl;

    amb_timing_sel #(.NUM_CS(NUM_CS)) u_tsel (
        .rd_tim_flat (cfg_rd_tim),
        .wr_tim_flat (cfg_wr_tim),
        .wr_sep      (cfg_wr_sep),
        .mux_en      (cfg_mux),
        .cs          (req_cs),
        .is_write    (req_write),
        .eff         (eff_tim)
    );

    assign start    = req_valid && (phase == PH_IDLE) && !done;
    assign wait_act = c_q.wen && (mem_wait == c_q.whi);

    amb_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_tim  (eff_tim),
        .wait_act   (wait_act),
        .phase      (phase),
        .done_pulse (done),
        .capture    (capture)
    );

    always_comb begin
        c_d = c_q;
        if (start) begin
            c_d.cs    = req_cs;
            c_d.wr    = req_write;
            c_d.addr  = req_addr;
            c_d.wdata = req_wdata;
            c_d.be    = req_be;
            c_d.mux   = cfg_mux[req_cs];
            c_d.wide  = cfg_wide[req_cs];
            c_d.wen   = cfg_wait_en[req_cs];
            c_d.whi   = cfg_wait_hi[req_cs];
        end
        if (capture && !c_q.wr)
            c_d.rdata = c_q.wide ? mem_dq_in : {8'h00, mem_dq_in[7:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    // bus outputs decoded from the registered phase
    always_comb begin
        in_addr    = (phase == PH_ASET) || (phase == PH_AHLD);
        in_data    = (phase == PH_DSET) || (phase == PH_DHLD);
        in_cs      = in_addr || in_data;
        in_bl      = in_cs || (phase == PH_BLS);
        mem_bl_n   = in_bl ? (c_q.wide ? ~c_q.be : 2'b10) : 2'b11;
        mem_oe_n   = !(!c_q.wr && in_data);
        mem_we_n   = !(c_q.wr && (phase == PH_DSET));
        mem_dq_oe  = (c_q.wr && in_data) || (c_q.mux && in_addr);
        if (c_q.mux && in_addr) mem_dq_out = c_q.addr[15:0];
        else if (c_q.wide)      mem_dq_out = c_q.wdata;
        else                    mem_dq_out = {8'h00, c_q.wdata[7:0]};
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign mem_cs_n[g] = !(in_cs && (c_q.cs == CS_W'(g)));
    end

    assign mem_addr  = c_q.addr;
    assign req_ack   = done;
    assign rsp_rdata = c_q.rdata;

    assert_one_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~mem_cs_n) <= 1);

    assert_strobes_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    assert_no_drive_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    assert_ack_idle_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (&mem_cs_n && mem_oe_n && mem_we_n));
endmodule

// File: tb/amb_seq_test.sv
module amb_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [0:0]  req_cs = '0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ack;
    logic [15:0] rsp_rdata;
    logic [47:0] cfg_rd_tim = '0, cfg_wr_tim = '0;
    logic [1:0]  cfg_wr_sep = '0, cfg_mux = '0, cfg_wide = '0, cfg_wait_en = '0, cfg_wait_hi = '0;
    logic [1:0]  mem_cs_n, mem_bl_n;
    logic [19:0] mem_addr;
    logic        mem_oe_n, mem_we_n, mem_dq_oe;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = '0;
    logic        mem_wait = 1'b1;

    int n_checks = 0, n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    amb_seq uut (.*);

    typedef struct packed {
        logic        wr;
        logic        cs;
        logic        mux;
        logic        wide;
        logic        wsep;
        logic [23:0] rt;
        logic [23:0] wt;
        logic [15:0] wdata;
        logic [1:0]  be;
    } vec_t;

    // timing word nibbles, high to low: turn dhld dset ahld aset bls
    localparam vec_t VEC [6] = '{
        '{wr:1'b0, cs:1'b0, mux:1'b0, wide:1'b1, wsep:1'b0, rt:24'h112321, wt:24'h000000, wdata:16'h0000, be:2'b11},
        '{wr:1'b1, cs:1'b1, mux:1'b1, wide:1'b1, wsep:1'b1, rt:24'h111111, wt:24'h213210, wdata:16'hBEEF, be:2'b01},
        '{wr:1'b0, cs:1'b1, mux:1'b1, wide:1'b0, wsep:1'b0, rt:24'h000110, wt:24'h000000, wdata:16'h0000, be:2'b11},
        '{wr:1'b1, cs:1'b0, mux:1'b0, wide:1'b0, wsep:1'b0, rt:24'h321002, wt:24'hFFFFFF, wdata:16'h1234, be:2'b11},
        '{wr:1'b0, cs:1'b0, mux:1'b0, wide:1'b1, wsep:1'b1, rt:24'h023010, wt:24'h555555, wdata:16'h0000, be:2'b10},
        '{wr:1'b1, cs:1'b0, mux:1'b0, wide:1'b1, wsep:1'b1, rt:24'h000000, wt:24'h000000, wdata:16'hC0DE, be:2'b11}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_txn(input vec_t v, input int idx, input logic wen, input logic whi,
                           input logic wdrive, input int extra, output int oe_cnt);
        logic [23:0] t;
        int bls, as_, ah, ds, dh, tu, ds_raw;
        int n_bls, n_cs, n_oe, n_we, n_dq, n_tot;
        int oe_seen;
        bit bad_bl, bad_wd, bad_ad, bad_oth, got_ack;
        logic [19:0] addr;
        logic [15:0] exp_wd, exp_rd, rd_at_ack;
        logic [1:0]  exp_bl;
        t      = (v.wr && v.wsep) ? {v.wt[23:4], v.rt[3:0]} : v.rt;
        bls    = int'(t[3:0]);
        as_    = int'(t[7:4]);
        ah     = v.mux ? int'(t[11:8]) : 0;
        ds_raw = int'(t[15:12]);
        ds     = (ds_raw == 0) ? 1 : ds_raw;
        dh     = int'(t[19:16]);
        tu     = int'(t[23:20]);
        addr   = 20'h5A000 + 20'(idx * 273);
        exp_wd = v.wide ? v.wdata : {8'h00, v.wdata[7:0]};
        exp_bl = v.wide ? ~v.be : 2'b10;
        exp_rd = 16'hA000 + 16'(bls + as_ + ah + ds - 1 + extra);
        if (!v.wide) exp_rd = exp_rd & 16'h00FF;
        n_bls = 0; n_cs = 0; n_oe = 0; n_we = 0; n_dq = 0; n_tot = 0; oe_seen = 0;
        bad_bl = 0; bad_wd = 0; bad_ad = 0; bad_oth = 0; got_ack = 0; rd_at_ack = '0;

        @(negedge clk);
        cfg_rd_tim  = {v.rt, v.rt};
        cfg_wr_tim  = {v.wt, v.wt};
        cfg_wr_sep  = {2{v.wsep}};
        cfg_mux     = {2{v.mux}};
        cfg_wide    = {2{v.wide}};
        cfg_wait_en = {2{wen}};
        cfg_wait_hi = {2{whi}};
        mem_wait    = wdrive ? whi : ~whi;
        req_write   = v.wr;
        req_cs      = v.cs;
        req_addr    = addr;
        req_wdata   = v.wdata;
        req_be      = v.be;
        req_valid   = 1'b1;
        for (int i = 0; i < 300 && !got_ack; i++) begin
            @(negedge clk);
            if (req_ack) begin
                got_ack   = 1;
                n_tot     = i;
                rd_at_ack = rsp_rdata;
                req_valid = 1'b0;
            end else begin
                if (mem_bl_n != 2'b11 && mem_cs_n[v.cs]) n_bls++;
                if (!mem_cs_n[v.cs]) n_cs++;
                if (!mem_cs_n[~v.cs]) bad_oth = 1;
                if (!mem_oe_n) begin n_oe++; oe_seen++; end
                if (!mem_we_n) begin
                    n_we++;
                    if (mem_dq_out != exp_wd) bad_wd = 1;
                end
                if (mem_dq_oe) n_dq++;
                if (mem_bl_n != 2'b11 && mem_bl_n != exp_bl) bad_bl = 1;
                if (v.mux && i >= bls && i < bls + as_ + ah &&
                    (mem_dq_out != addr[15:0] || !mem_dq_oe)) bad_ad = 1;
                mem_dq_in = 16'hA000 + 16'(i);
                if (wdrive && oe_seen == 4) mem_wait = ~whi;
            end
        end
        req_valid = 1'b0;
        chk($sformatf("R10 ack seen v%0d", idx), int'(got_ack), 1);
        chk($sformatf("R2 byte-lane setup cycles v%0d", idx), n_bls, bls);
        chk($sformatf("R2 select-low cycles v%0d", idx), n_cs, as_ + ah + ds + dh + extra);
        chk($sformatf("R4 total cycles to ack v%0d", idx), n_tot, bls + as_ + ah + ds + dh + tu + extra);
        chk($sformatf("R5 oe cycles v%0d", idx), n_oe, v.wr ? 0 : ds + dh + extra);
        chk($sformatf("%s v%0d", (ds_raw == 0 && v.wr) ? "R3 min data setup we cycles" : "R5 we cycles", idx),
            n_we, v.wr ? ds : 0);
        chk($sformatf("R6 drive cycles v%0d", idx), n_dq, (v.wr ? ds + dh : 0) + (v.mux ? as_ + ah : 0));
        chk($sformatf("R6 write data v%0d", idx), int'(bad_wd), 0);
        chk($sformatf("R6 mux address v%0d", idx), int'(bad_ad), 0);
        chk($sformatf("R8 byte lanes v%0d", idx), int'(bad_bl), 0);
        chk($sformatf("R1 other select high v%0d", idx), int'(bad_oth), 0);
        if (!v.wr) chk($sformatf("R7 read data v%0d", idx), int'(rd_at_ack), int'(exp_rd));
        oe_cnt = n_oe;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int oe;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 cs_n at reset", int'(mem_cs_n), 3);
        chk("R11 oe_n/we_n at reset", int'({mem_oe_n, mem_we_n}), 3);
        chk("R11 bl_n at reset", int'(mem_bl_n), 3);
        chk("R11 dq_oe at reset", int'(mem_dq_oe), 0);
        chk("R11 ack at reset", int'(req_ack), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle without request", int'(mem_cs_n), 3);

        foreach (VEC[k]) begin
            run_txn(VEC[k], k, 1'b0, 1'b0, 1'b0, 0, oe);
            @(negedge clk);
        end

        // R9 wait active low, enabled: three extra data-setup cycles
        run_txn(VEC[0], 10, 1'b1, 1'b0, 1'b1, 3, oe);
        chk("R9 active-low wait stretch", oe, 2 + 1 + 3);
        // R9 wait active high, enabled
        run_txn(VEC[4], 11, 1'b1, 1'b1, 1'b1, 3, oe);
        chk("R9 active-high wait stretch", oe, 3 + 2 + 3);
        // R9 wait disabled: asserted level ignored
        run_txn(VEC[0], 12, 1'b0, 1'b0, 1'b1, 0, oe);
        chk("R9 wait disabled no stretch", oe, 2 + 1);

        repeat (2) @(negedge clk);
        chk("R10 no stray ack after access", int'(req_ack), 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule